// File: doc/BRIEF.md
# Three-Wire Clock-Chip Register Access Engine

This block lets on-chip logic read or write one byte register of an external clock/calendar chip over a three-wire serial link. The link has a frame select line, a serial clock and one bidirectional data line. The data line appears at the block edge as an output, an output enable and an input, so the pad ring can build the tri-state buffer.

The host presents a 7-bit register number, a direction flag and, for writes, a data byte, and pulses `start`. The engine opens a frame and shifts out a command byte that carries the direction and the register number. A write then shifts out the data byte. A read releases the data line and clocks in the chip's byte. The engine then closes the frame and pulses `done`. On a read, `rdata` holds the received byte.

All link timing is built from one bit period of `DIV` system clocks. A write frame lasts 51 periods and a read frame lasts 42 periods.

Top module: `rtc_serial_master`

## Requirements
- R1: After a synchronous active-high reset, `ce_o`, `sclk_o`, `sdata_o`, `busy` and `done` are low, and `sdata_oe` is high. The engine drives the data line low while it is idle.
- R2: A frame opens with `ce_o` rising while `sclk_o` and `sdata_o` are low. These stay low for one full bit period. The first `sclk_o` rising edge comes exactly two bit periods (2*DIV system clocks) after `ce_o` rises.
- R3: The command byte is shifted most significant bit first. Bit 7 is 1 for a write and 0 for a read, and bits 6..0 carry the register number.
- R4: Every transmitted bit holds `sdata_o` for one period with `sclk_o` low, then one period with `sclk_o` high, then one period with `sclk_o` low. Every `sclk_o` high pulse lasts exactly DIV clocks, and `sdata_o` does not change while `sclk_o` is high.
- R5: A write inserts one idle period after the command byte, then shifts out the data byte MSB first with the R4 timing. `busy` stays high for exactly 51*DIV+1 clocks.
- R6: A read follows the command byte at once with 8 clock pulses, each one period high and one period low. `sdata_oe` is low through this phase. `sdata_i` is sampled at the end of each low period, MSB first, and the received byte appears on `rdata` with `done`. `busy` stays high for exactly 42*DIV+1 clocks.
- R7: A frame closes with `ce_o`, `sclk_o` and `sdata_o` all low for exactly one bit period before `done`. `done` is a single-cycle pulse.
- R8: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` that arrives while `busy` is high is ignored: no second frame runs and no register is written.
- R9: `sclk_o` is never high and `sdata_oe` is never low while `ce_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one transaction (taken only when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 7 | Register number |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte received by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ce_o | output | 1 | Frame select to the clock chip |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data driven by the engine |
| sdata_oe | output | 1 | Output enable for the data pad (1 = engine drives) |
| sdata_i | input | 1 | Serial data read back from the pad |

## Verification
Assertions check the pin relations on every cycle:
- `sclk_o` and the pad release stay inside the frame select window.
- The frame opens quietly and ends quietly.
- Data holds steady while the clock is high.
- `done` is a single pulse, and `busy` holds until `done`.

Only the bench scenarios can show the rest. A behavioural clock-chip model checks the decoded command and data bytes, the read bytes returned MSB first, and the exact frame lengths and pulse widths in cycles. The scenarios also show that a `start` during a frame leaves the chip's registers untouched.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 1 + ADDR_W + BYTE_W;

    // frame phases, in the order a transaction visits them
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_CMD,
        PH_GAP,
        PH_WDAT,
        PH_RDAT,
        PH_TAIL,
        PH_FIN
    } phase_e;

    // sub-steps of one serial bit
    typedef enum logic [1:0] {
        ST_SETUP = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2
    } step_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] reg_no;
    } cmd_t;

    function automatic logic [FRAME_W-1:0] pack_frame(input cmd_t c,
                                                      input logic [BYTE_W-1:0] d);
        return {c.wr, c.reg_no, d};
    endfunction

    function automatic logic is_tx_phase(input phase_e p);
        return (p == PH_CMD) || (p == PH_WDAT);
    endfunction

    function automatic logic is_clocked_phase(input phase_e p);
        return (p == PH_CMD) || (p == PH_WDAT) || (p == PH_RDAT);
    endfunction

    function automatic logic in_frame(input phase_e p);
        return (p == PH_LEAD) || (p == PH_CMD) || (p == PH_GAP) ||
               (p == PH_WDAT) || (p == PH_RDAT);
    endfunction

endpackage

// File: rtl/rtc_bit_timer.sv
module rtc_bit_timer #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/rtc_shift_reg.sv
module rtc_shift_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic         msb,
    output logic [7:0]   low_byte
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (load)
            sr <= load_val;
        else if (shift)
            sr <= {sr[W-2:0], ser_in};
    end

    assign msb      = sr[W-1];
    assign low_byte = sr[7:0];
endmodule

// File: rtl/rtc_frame_seq.sv
module rtc_frame_seq
    import rtc_ser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   wr,
    input  logic   tick,
    output phase_e phase,
    output step_e  step,
    output logic   wr_q,
    output logic   load,
    output logic   shift
);
    logic [2:0] bitn;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= ST_SETUP;
            bitn  <= '0;
            wr_q  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_LEAD;
                    wr_q  <= wr;
                end
                PH_LEAD: if (tick) begin
                    phase <= PH_CMD;
                    step  <= ST_SETUP;
                    bitn  <= '0;
                end
                PH_CMD, PH_WDAT: if (tick) begin
                    unique case (step)
                        ST_SETUP: step <= ST_HIGH;
                        ST_HIGH:  step <= ST_LOW;
                        default: begin
                            if (bitn == 3'd7) begin
                                bitn <= '0;
                                if (phase == PH_WDAT)
                                    phase <= PH_TAIL;
                                else if (wr_q)
                                    phase <= PH_GAP;
                                else begin
                                    phase <= PH_RDAT;
                                    step  <= ST_HIGH;
                                end
                            end else begin
                                bitn <= bitn + 1'b1;
                                step <= ST_SETUP;
                            end
                        end
                    endcase
                end
                PH_GAP: if (tick) begin
                    phase <= PH_WDAT;
                    step  <= ST_SETUP;
                end
                PH_RDAT: if (tick) begin
                    if (step == ST_HIGH)
                        step <= ST_LOW;
                    else if (bitn == 3'd7) begin
                        bitn  <= '0;
                        phase <= PH_TAIL;
                        step  <= ST_SETUP;
                    end else begin
                        bitn <= bitn + 1'b1;
                        step <= ST_HIGH;
                    end
                end
                PH_TAIL: if (tick) phase <= PH_FIN;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign load  = (phase == PH_IDLE) && start;
    assign shift = tick && (step == ST_LOW) && is_clocked_phase(phase);

    // R4: a serial bit only leaves its low step on a period boundary
    assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (is_clocked_phase(phase) && !tick) |=> $stable(step));
endmodule

// File: rtl/rtc_serial_master.sv
module rtc_serial_master
    import rtc_ser_pkg::*;
#(
    parameter int DIV = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 ce_o,
    output logic                 sclk_o,
    output logic                 sdata_o,
    output logic                 sdata_oe,
    input  logic                 sdata_i
);
    phase_e phase;
    step_e  step;
    logic   wr_q, load, shift, tick, run, msb, ser_in;
    logic [7:0] low_byte;
    cmd_t   cmd;

    assign cmd.wr     = wr;
    assign cmd.reg_no = addr;
    assign run        = (phase != PH_IDLE) && (phase != PH_FIN);
    assign ser_in     = (phase == PH_RDAT) ? sdata_i : 1'b0;

    rtc_bit_timer #(.DIV(DIV)) u_timer (
        .clk(clk), .rst(rst), .run(run), .tick(tick)
    );

    rtc_frame_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .wr(wr), .tick(tick),
        .phase(phase), .step(step), .wr_q(wr_q), .load(load), .shift(shift)
    );

    rtc_shift_reg #(.W(FRAME_W)) u_sr (
        .clk(clk), .rst(rst), .load(load), .load_val(pack_frame(cmd, wdata)),
        .shift(shift), .ser_in(ser_in), .msb(msb), .low_byte(low_byte)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (phase == PH_TAIL && tick && !wr_q)
            rdata <= low_byte;
    end

    assign busy     = (phase != PH_IDLE);
    assign done     = (phase == PH_FIN);
    assign ce_o     = in_frame(phase);
    assign sclk_o   = is_clocked_phase(phase) && (step == ST_HIGH);
    assign sdata_o  = is_tx_phase(phase) && msb;
    assign sdata_oe = (phase != PH_RDAT);

    // R9: no clock and no pad release outside the frame select window
    assert_sclk_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> ce_o);
    assert_release_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        !sdata_oe |-> ce_o);
    // R2: the frame opens with clock and data low
    assert_quiet_open_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_o) |-> (!sclk_o && !sdata_o));
    // R4: data holds while the clock is high
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
    // R7: done is one cycle, with all link lines low
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_quiet_close_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ce_o && !sclk_o && !sdata_o));
    // R8: busy holds until done
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: tb/sim_rtc_serial_master.sv
module sim_rtc_serial_master;
    localparam int DIV = 4;
    localparam int WR_CYC = 51 * DIV + 1;
    localparam int RD_CYC = 42 * DIV + 1;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, wr = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic busy, done, ce_o, sclk_o, sdata_o, sdata_oe;
    logic sdata_i = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rtc_serial_master #(.DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .start(start), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
        .ce_o(ce_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
        .sdata_oe(sdata_oe), .sdata_i(sdata_i)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // ---- behavioural clock-chip model ----
    logic [7:0] slv_mem [128];
    logic [7:0] ref_mem [128];
    logic [7:0] s_cmd, s_dat;
    int s_bits = 0, s_frames = 0, s_fight = 0;

    always @(posedge ce_o) begin s_bits = 0; s_cmd = '0; s_dat = '0; end
    always @(negedge ce_o) s_frames++;

    always @(posedge sclk_o) if (ce_o) begin
        if (s_bits < 8) s_cmd = {s_cmd[6:0], sdata_o};
        else if (s_cmd[7]) s_dat = {s_dat[6:0], sdata_o};
        else if (sdata_oe) s_fight++;
        s_bits++;
        if (s_bits == 16 && s_cmd[7]) slv_mem[s_cmd[6:0]] = s_dat;
    end

    always @(negedge sclk_o) if (ce_o && s_bits >= 9 && !s_cmd[7])
        sdata_i = slv_mem[s_cmd[6:0]][16 - s_bits];

    // ---- scoreboard ----
    typedef struct {
        bit         rd;
        logic [7:0] cmd;
        logic [7:0] data;
        int         cycles;
    } item_t;
    item_t sb[$];

    int busy_cnt = 0, lead_cnt = 0, first_gap = -1, tail_cnt = 0;
    int hi_cnt = 0, bad_width = 0;
    bit seen_clk = 0, prev_sclk = 0, prev_done = 0;

    always @(negedge clk) if (!rst) begin
        if (busy) busy_cnt++;
        if (ce_o && !seen_clk) begin
            if (sclk_o) begin seen_clk = 1; first_gap = lead_cnt; end
            else lead_cnt++;
        end
        if (sclk_o) hi_cnt++;
        else if (prev_sclk) begin
            if (hi_cnt != DIV) bad_width++;
            hi_cnt = 0;
        end
        prev_sclk = sclk_o;
        if (busy && !ce_o && seen_clk && !done) tail_cnt++;
        if (done && prev_done) chk(0, "R7", "done wider than one cycle", 2, 1);
        if (done && !prev_done) begin
            item_t it;
            if (sb.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
            else begin
                it = sb.pop_front();
                chk(s_cmd == it.cmd, "R3", "command byte", s_cmd, it.cmd);
                chk(first_gap == 2*DIV, "R2", "ce to first sclk", first_gap, 2*DIV);
                chk(bad_width == 0, "R4", "sclk high widths off", bad_width, 0);
                chk(tail_cnt == DIV, "R7", "closing quiet period", tail_cnt, DIV);
                if (it.rd) begin
                    chk(rdata == it.data, "R6", "read byte", rdata, it.data);
                    chk(s_fight == 0, "R6", "pad driven in read", s_fight, 0);
                    chk(busy_cnt == it.cycles, "R6", "read busy cycles", busy_cnt, it.cycles);
                end else begin
                    chk(s_dat == it.data, "R5", "written byte", s_dat, it.data);
                    chk(busy_cnt == it.cycles, "R5", "write busy cycles", busy_cnt, it.cycles);
                end
            end
            busy_cnt = 0; lead_cnt = 0; first_gap = -1; tail_cnt = 0;
            bad_width = 0; seen_clk = 0; s_fight = 0;
        end
        prev_done = done;
    end

    task automatic run_txn(input bit rd, input logic [6:0] a,
                           input logic [7:0] d, input bit poke);
        item_t it;
        it.rd     = rd;
        it.cmd    = {~rd, a};
        it.data   = rd ? ref_mem[a] : d;
        it.cycles = rd ? RD_CYC : WR_CYC;
        if (!rd) ref_mem[a] = d;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b1; wr = ~rd; addr = a; wdata = d;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1; wr = 1'b1; addr = 7'h03; wdata = 8'hEE;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R8", "idle after done", busy, 0);
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int frames0;
        for (int i = 0; i < 128; i++) begin
            slv_mem[i] = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        chk(!ce_o && !sclk_o && !sdata_o, "R1", "link idle in reset",
            {ce_o, sclk_o, sdata_o}, 0);
        chk(sdata_oe == 1'b1, "R1", "pad driven in reset", sdata_oe, 1);
        chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !ce_o, "R1", "idle after reset", {busy, ce_o}, 0);

        run_txn(1, 7'h10, 8'h00, 0);          // R6 plain read
        run_txn(0, 7'h7F, 8'hA5, 0);          // R5 write top register
        run_txn(1, 7'h7F, 8'h00, 0);          // R6 read back
        run_txn(0, 7'h00, 8'hFF, 0);          // R3 register 0
        run_txn(1, 7'h00, 8'h00, 0);
        run_txn(0, 7'h2A, 8'h00, 0);
        run_txn(1, 7'h2A, 8'h00, 0);
        frames0 = s_frames;
        run_txn(0, 7'h41, 8'h3C, 1);          // R8 start poked during frame
        chk(s_frames == frames0 + 1, "R8", "frames for poked write",
            s_frames, frames0 + 1);
        run_txn(1, 7'h03, 8'h00, 0);          // R8 register 3 untouched
        run_txn(1, 7'h41, 8'h00, 1);          // R8 poke during a read

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule